// File: doc/BRIEF.md
# Multi-Input Reference Prescaler and Monitor

This block conditions a set of reference clock inputs before they reach a clock synchronizer. Each reference is brought into a fast system clock domain, and its rising edges are detected there. Each input can then pass every edge straight through as a one-cycle strobe. It can instead be sent through an integer divider that emits one strobe per N+1 edges. A single divide ratio N is shared by every input that uses the divider.

Each input also has an activity monitor and a frequency monitor. The activity monitor flags an input that has gone quiet for a programmable number of system clocks. The frequency monitor counts edges over a fixed gate window and compares the count with an expected value. The frequency monitor runs only while no input uses the divider. Once any input engages the divider, frequency checking stops on every input, and activity checking carries on.

Configuration is written through a simple address/data write port. The SONET/SDH mode bit is taken from a strap pin while reset is held. That pin also picks the default expected count for every input.

Top module: `refclk_prescaler`

## Requirements
- R1: An input that does not engage the divider produces exactly one `ref_strobe` pulse, one cycle wide, for every rising edge of its reference.
- R2: An engaged input produces one strobe on every (N+1)th rising edge, counted from the last restart. With N = 0, it produces a strobe on every edge.
- R3: All engaged inputs divide by the same N, which is written at address 0.
- R4: A write to address 0 with a value of 16383 or more stores 16382. Smaller values are stored as written. The stored ratio is visible on `div_n`.
- R5: A write to address 0 (ratio) or address 1 (enable mask) clears the divide count of every input. A write to address 4+i clears the divide count of input i.
- R6: Input i engages the divider only when bit i of the enable mask (address 1) is set and bit 6 (lock-to-8k) of its frequency word (address 4+i) is set. Otherwise it behaves as in R1.
- R7: `freq_mon_on` is 1 exactly when no input engages the divider. While it is 0, every `freq_bad` bit is 0.
- R8: While frequency monitoring is on, `freq_bad[i]` is set at the end of each 256-cycle gate if the rising-edge count of that gate differs by more than 2 from bits [5:0] of the frequency word. Otherwise the bit is cleared.
- R9: `ref_inactive[i]` goes to 1 once no edge has been seen for the timeout count (address 3, in system clocks). It returns to 0 on the next edge. This holds whether or not the divider is engaged.
- R10: While reset is held, the mode bit loads from `strap_sonet` and the ratio and enable mask clear. Each frequency word is set to lock-to-8k 0 with an expected count of 32 in SONET mode or 16 in SDH mode. The strobes and flags are 0, and `freq_mon_on` is 1.
- R11: Bit 2 of a write to address 2 sets the mode (1 = SONET, 0 = SDH), which is shown on `mode_sonet`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_sonet | input | 1 | Strap level loaded into the mode bit during reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| ref_in | input | NUM_IN | Asynchronous reference clock inputs |
| ref_strobe | output | NUM_IN | One-cycle strobes, divided or passed through |
| ref_inactive | output | NUM_IN | Activity timeout flags |
| freq_bad | output | NUM_IN | Frequency out-of-range flags |
| freq_mon_on | output | 1 | Frequency monitoring globally enabled |
| mode_sonet | output | 1 | Current mode, 1 = SONET |
| div_n | output | 14 | Stored shared divide ratio N |

## Verification
The hardest case to reach is a restart in the middle of a division. The divide counter must be cleared by a config write at a point where the count differs from the value it would reach anyway. The bench therefore stops the free-running references and drives hand-made single pulses. It leaves the counter part-way, rewrites the same ratio, and then counts pulses up to the next strobe. Randomized runs then mix ratios, enable masks, lock-to-8k bits and per-input periods. Each strobe total is compared with the number of edges the bench itself drove.

// File: rtl/refpre_pkg.sv
package refpre_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned A_DIVN   = 0;
  localparam int unsigned A_DIVEN  = 1;
  localparam int unsigned A_MODE   = 2;
  localparam int unsigned A_TMO    = 3;
  localparam int unsigned A_FREQ0  = 4;
  localparam int unsigned MODE_BIT = 2;
  localparam int unsigned LOCK_BIT = 6;
  localparam int unsigned EXP_W    = 6;

  typedef struct packed {
    logic             lock8k;
    logic [EXP_W-1:0] exp_cnt;
  } freq_cfg_t;
endpackage

// File: rtl/refpre_edge_sync.sv
module refpre_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic ref_async,
  output logic edge_p
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[1:0], ref_async};
  end

  // sh[0], sh[1] are the two synchronizer stages, sh[2] the history bit
  assign edge_p = sh[1] & ~sh[2];
endmodule

// File: rtl/refpre_divider.sv
module refpre_divider #(
  parameter int unsigned DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             engage,
  input  logic [DIV_W-1:0] div_n,
  input  logic             edge_p,
  output logic             strobe
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (edge_p) begin
        if (!engage) begin
          strobe <= 1'b1;
        end else if (cnt == div_n) begin
          cnt    <= '0;
          strobe <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/refpre_activity.sv
module refpre_activity #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_p,
  input  logic [TMO_W-1:0] tmo,
  output logic             inactive
);
  logic [TMO_W-1:0] timer;

  always_ff @(posedge clk) begin
    if (rst) begin
      timer    <= '0;
      inactive <= 1'b0;
    end else if (edge_p) begin
      timer    <= '0;
      inactive <= 1'b0;
    end else if (timer >= tmo) begin
      inactive <= 1'b1;
    end else begin
      timer <= timer + 1'b1;
    end
  end
endmodule

// File: rtl/refpre_freqmon.sv
module refpre_freqmon #(
  parameter int unsigned GATE_CYC = 256,
  parameter int unsigned EXP_W    = 6,
  parameter int unsigned TOL      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             edge_p,
  input  logic [EXP_W-1:0] exp_cnt,
  output logic             bad
);
  localparam int unsigned GW    = $clog2(GATE_CYC);
  localparam int unsigned CW    = GW + 1;
  localparam int unsigned CMP_W = ((CW > EXP_W) ? CW : EXP_W) + 1;

  logic [GW-1:0]    gcnt;
  logic [CW-1:0]    ecnt;
  logic [CMP_W-1:0] tot, expv, diff;

  assign tot  = CMP_W'(ecnt) + CMP_W'(edge_p);
  assign expv = CMP_W'(exp_cnt);
  assign diff = (tot > expv) ? (tot - expv) : (expv - tot);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gcnt <= '0;
      ecnt <= '0;
      bad  <= 1'b0;
    end else if (gcnt == GW'(GATE_CYC - 1)) begin
      gcnt <= '0;
      ecnt <= '0;
      bad  <= (diff > CMP_W'(TOL));
    end else begin
      gcnt <= gcnt + 1'b1;
      ecnt <= ecnt + CW'(edge_p);
    end
  end
endmodule

// File: rtl/refclk_prescaler.sv
module refclk_prescaler
  import refpre_pkg::*;
#(
  parameter int unsigned NUM_IN        = 4,
  parameter int unsigned DIV_W         = 14,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned TMO_W         = 16,
  parameter int unsigned TMO_DEF       = 1000,
  parameter int unsigned GATE_CYC      = 256,
  parameter int unsigned TOL           = 2,
  parameter int unsigned DEF_EXP_SONET = 32,
  parameter int unsigned DEF_EXP_SDH   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_sonet,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NUM_IN-1:0] ref_in,
  output logic [NUM_IN-1:0] ref_strobe,
  output logic [NUM_IN-1:0] ref_inactive,
  output logic [NUM_IN-1:0] freq_bad,
  output logic              freq_mon_on,
  output logic              mode_sonet,
  output logic [DIV_W-1:0]  div_n
);
  localparam int unsigned DIV_MAX = (1 << DIV_W) - 2;

  logic [NUM_IN-1:0] div_en;
  logic [NUM_IN-1:0] engage;
  logic [TMO_W-1:0]  tmo;
  logic              freq_en;
  logic              wr_ratio, wr_mask;

  assign wr_ratio = wr_en && (wr_addr == ADDR_W'(A_DIVN));
  assign wr_mask  = wr_en && (wr_addr == ADDR_W'(A_DIVEN));
  assign freq_en  = ~|engage;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_n       <= '0;
      div_en      <= '0;
      tmo         <= TMO_W'(TMO_DEF);
      mode_sonet  <= strap_sonet;
      freq_mon_on <= 1'b1;
    end else begin
      freq_mon_on <= freq_en;
      if (wr_ratio) begin
        if (wr_data > DATA_W'(DIV_MAX)) div_n <= DIV_W'(DIV_MAX);
        else                            div_n <= wr_data[DIV_W-1:0];
      end
      if (wr_mask) div_en <= wr_data[NUM_IN-1:0];
      if (wr_en && (wr_addr == ADDR_W'(A_MODE))) mode_sonet <= wr_data[MODE_BIT];
      if (wr_en && (wr_addr == ADDR_W'(A_TMO)))  tmo <= wr_data[TMO_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    freq_cfg_t fcfg;
    logic      wr_own, edge_p, restart;

    assign wr_own    = wr_en && (wr_addr == ADDR_W'(A_FREQ0 + i));
    assign restart   = wr_ratio || wr_mask || wr_own;
    assign engage[i] = div_en[i] & fcfg.lock8k;

    always_ff @(posedge clk) begin
      if (rst) begin
        fcfg.lock8k  <= 1'b0;
        fcfg.exp_cnt <= strap_sonet ? EXP_W'(DEF_EXP_SONET) : EXP_W'(DEF_EXP_SDH);
      end else if (wr_own) begin
        fcfg.lock8k  <= wr_data[LOCK_BIT];
        fcfg.exp_cnt <= wr_data[EXP_W-1:0];
      end
    end

    refpre_edge_sync u_sync (
      .clk(clk), .rst(rst), .ref_async(ref_in[i]), .edge_p(edge_p)
    );

    refpre_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst(rst), .restart(restart), .engage(engage[i]),
      .div_n(div_n), .edge_p(edge_p), .strobe(ref_strobe[i])
    );

    refpre_activity #(.TMO_W(TMO_W)) u_act (
      .clk(clk), .rst(rst), .edge_p(edge_p), .tmo(tmo),
      .inactive(ref_inactive[i])
    );

    refpre_freqmon #(.GATE_CYC(GATE_CYC), .EXP_W(EXP_W), .TOL(TOL)) u_fm (
      .clk(clk), .rst(rst), .en(freq_en), .edge_p(edge_p),
      .exp_cnt(fcfg.exp_cnt), .bad(freq_bad[i])
    );
  end
endmodule

// File: rtl/refclk_prescaler_chk.sv
module refclk_prescaler_chk
  import refpre_pkg::*;
#(
  parameter int unsigned NUM_IN = 4,
  parameter int unsigned DIV_W  = 14,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              strap_sonet,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NUM_IN-1:0] ref_strobe,
  input logic [NUM_IN-1:0] freq_bad,
  input logic              freq_mon_on,
  input logic              mode_sonet,
  input logic [DIV_W-1:0]  div_n
);
  localparam int unsigned DIV_MAX = (1 << DIV_W) - 2;

  // R1 R2: strobes are single-cycle pulses
  a_r2_strobe_single_cycle: assert property (@(posedge clk) disable iff (rst)
    (ref_strobe & $past(ref_strobe)) == '0);

  // R7: no frequency alarm while monitoring is off
  a_r7_monitor_off_silent: assert property (@(posedge clk) disable iff (rst)
    !freq_mon_on |-> (freq_bad == '0));

  // R4: stored ratio never exceeds the clamp value
  a_r4_div_n_in_range: assert property (@(posedge clk) disable iff (rst)
    div_n <= DIV_W'(DIV_MAX));

  // R10: mode leaves reset holding the strap level
  a_r10_strap_loaded: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mode_sonet == $past(strap_sonet)));

  // R11: mode register write lands on the next cycle
  a_r11_mode_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == ADDR_W'(A_MODE))) |=> (mode_sonet == $past(wr_data[MODE_BIT])));
endmodule

bind refclk_prescaler refclk_prescaler_chk #(
  .NUM_IN(NUM_IN), .DIV_W(DIV_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .strap_sonet(strap_sonet), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .ref_strobe(ref_strobe),
  .freq_bad(freq_bad), .freq_mon_on(freq_mon_on), .mode_sonet(mode_sonet),
  .div_n(div_n)
);

// File: tb/refclk_prescaler_bench.sv
`timescale 1ns/1ps
module refclk_prescaler_bench;
  localparam int NI = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_sonet = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [NI-1:0] ref_in = '0;
  logic [NI-1:0] ref_strobe, ref_inactive, freq_bad;
  logic        freq_mon_on, mode_sonet;
  logic [13:0] div_n;

  int vectors = 0;
  int miscompares = 0;
  int half [NI];
  int edges [NI];
  int scnt [NI];
  bit run [NI];
  bit done = 1'b0;

  always #2 clk = ~clk;

  refclk_prescaler u_refclk_prescaler (
    .clk(clk), .rst(rst), .strap_sonet(strap_sonet), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ref_in(ref_in),
    .ref_strobe(ref_strobe), .ref_inactive(ref_inactive), .freq_bad(freq_bad),
    .freq_mon_on(freq_mon_on), .mode_sonet(mode_sonet), .div_n(div_n)
  );

  for (genvar g = 0; g < NI; g++) begin : g_gen
    initial begin
      half[g] = 4; edges[g] = 0; scnt[g] = 0; run[g] = 1'b0;
      forever begin
        repeat (half[g]) @(negedge clk);
        if (run[g]) begin
          ref_in[g] = ~ref_in[g];
          if (ref_in[g]) edges[g]++;
        end
      end
    end
    always @(negedge clk) if (ref_strobe[g]) scnt[g]++;
  end

  function automatic int exp_strobes(int e, bit eng, int n);
    return eng ? e / (n + 1) : e;
  endfunction

  task automatic chk(string req, int act, int expv);
    vectors++;
    if (act != expv) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(bit s);
    @(negedge clk);
    rst = 1'b1; strap_sonet = s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic stop_all();
    for (int i = 0; i < NI; i++) run[i] = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic clear_counts();
    for (int i = 0; i < NI; i++) begin edges[i] = 0; scnt[i] = 0; end
  endtask

  task automatic pulse(int i);
    ref_in[i] = 1'b0;
    repeat (3) @(negedge clk);
    ref_in[i] = 1'b1; edges[i]++;
    repeat (4) @(negedge clk);
    ref_in[i] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rand_iter(int n, int en, int lk);
    int eng;
    stop_all();
    for (int i = 0; i < NI; i++) wr(4 + i, ((lk >> i) & 1) * 64 + 32);
    wr(0, n);
    wr(1, en);
    eng = en & lk & 15;
    clear_counts();
    for (int i = 0; i < NI; i++) run[i] = 1'b1;
    repeat (400) @(negedge clk);
    stop_all();
    for (int i = 0; i < NI; i++)
      chk($sformatf("R1/R2/R3/R6 in%0d N=%0d", i, n), scnt[i],
          exp_strobes(edges[i], bit'((eng >> i) & 1), n));
    chk("R7 freq_mon_on", int'(freq_mon_on), int'(eng == 0));
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // R10: reset state, SDH strap
    do_reset(1'b0);
    @(negedge clk);
    chk("R10 mode after SDH strap", int'(mode_sonet), 0);
    chk("R10 div_n", int'(div_n), 0);
    chk("R10 strobes", int'(ref_strobe), 0);
    chk("R10 inactive", int'(ref_inactive), 0);
    chk("R10 freq_mon_on", int'(freq_mon_on), 1);

    // R10/R8: default expected count follows strap (16 SDH vs 32 SONET)
    half[0] = 8; run[0] = 1'b1;
    repeat (700) @(negedge clk);
    chk("R10 SDH default count 16 matches", int'(freq_bad[0]), 0);
    do_reset(1'b1);
    @(negedge clk);
    chk("R10 mode after SONET strap", int'(mode_sonet), 1);
    repeat (700) @(negedge clk);
    chk("R10 SONET default count 32 mismatches", int'(freq_bad[0]), 1);
    run[0] = 1'b0;

    // R11: mode register
    wr(2, 16'h0000); @(negedge clk);
    chk("R11 mode write 0", int'(mode_sonet), 0);
    wr(2, 16'h0004); @(negedge clk);
    chk("R11 mode write 1", int'(mode_sonet), 1);

    // R4: clamp
    wr(0, 16383); chk("R4 clamp 16383", int'(div_n), 16382);
    wr(0, 16'hFFFF); chk("R4 clamp 65535", int'(div_n), 16382);
    wr(0, 16382); chk("R4 max legal", int'(div_n), 16382);
    wr(0, 100); chk("R4 small value", int'(div_n), 100);

    // R1/R2/R3/R6: directed then random
    for (int i = 0; i < NI; i++) half[i] = 2 + i;
    rand_iter(0, 15, 15);
    rand_iter(5, 15, 15);
    rand_iter(3, 15, 0);
    rand_iter(2, 5, 15);
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < NI; i++) half[i] = 2 + int'($urandom % 4);
      rand_iter(int'($urandom % 6), int'($urandom % 16), int'($urandom % 16));
    end

    // R5: restart clears a part-way count
    stop_all();
    wr(4, 64 + 32); wr(0, 3); wr(1, 1);
    clear_counts();
    pulse(0); pulse(0);
    repeat (4) @(negedge clk);
    wr(0, 3);
    scnt[0] = 0;
    pulse(0); pulse(0); pulse(0);
    repeat (4) @(negedge clk);
    chk("R5 no strobe 3 edges after restart", scnt[0], 0);
    pulse(0);
    repeat (4) @(negedge clk);
    chk("R5 strobe on 4th edge after restart", scnt[0], 1);

    // R9: activity with divider engaged
    wr(3, 100);
    wr(5, 64 + 32); wr(1, 2);
    half[1] = 3; run[1] = 1'b1;
    repeat (100) @(negedge clk);
    chk("R9 active while toggling", int'(ref_inactive[1]), 0);
    run[1] = 1'b0;
    repeat (50) @(negedge clk);
    chk("R9 not yet timed out", int'(ref_inactive[1]), 0);
    repeat (90) @(negedge clk);
    chk("R9 timed out", int'(ref_inactive[1]), 1);
    pulse(1);
    chk("R9 cleared by edge", int'(ref_inactive[1]), 0);

    // R8/R7: frequency monitor
    wr(1, 0);
    wr(6, 32);
    half[2] = 4; run[2] = 1'b1;
    repeat (700) @(negedge clk);
    chk("R8 in range", int'(freq_bad[2]), 0);
    chk("R7 on with no divider", int'(freq_mon_on), 1);
    wr(6, 20);
    repeat (600) @(negedge clk);
    chk("R8 out of range", int'(freq_bad[2]), 1);
    wr(4, 64 + 32); wr(1, 1);
    repeat (3) @(negedge clk);
    chk("R7 off when divider engaged", int'(freq_mon_on), 0);
    chk("R7 alarm cleared", int'(freq_bad[2]), 0);
    repeat (600) @(negedge clk);
    chk("R7 alarm stays off", int'(freq_bad[2]), 0);
    run[2] = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule